// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the programming port of a fractional-N synthesizer and modulator. An external controller drives three pins: a serial clock, a serial data line and an active-low frame enable. While the enable is low, the block shifts one data bit into a 16-bit word on each rising edge of the serial clock, most significant bit first. When the enable rises, the block stores the word in one of four registers. The register is chosen by the two least significant bits of the word. The remaining 14 bits are the payload.

Two of the addresses each hold one half of a 28-bit fractional divide value. The third address holds the integer divide value and the settings for the reference divider and the charge pump. The fourth holds the configuration flags. Every field is presented as a parallel output, starting from fixed reset values. All three serial pins are synchronised into the system clock domain. A chip-level hardware shutdown input freezes the port. The software power-down flag does not freeze it.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset the outputs are as follows: `frac_word` is 0, `int_div` equals parameter `INT_RST` (default 35), `ref_sel`, `cp_cur` and `cp_comp` are 0, `mod_en` and `buf_en` are 1, and `int_mode`, `pwr_dn` and `cp_double` are 0.
- R2: While `ser_en_n` is low, each rising edge of `ser_clk` shifts `ser_data` into the word, most significant bit first. In the resulting 16-bit word, bits [15:2] are the payload and bits [1:0] are the address.
- R3: A rising edge of `ser_en_n` writes the payload into the single register selected by the address. The other three registers keep their values.
- R4: A frame whose bit count is not exactly 16 when `ser_en_n` rises is discarded, and every output keeps its value.
- R5: Address 0 writes payload bits [13:0] into `frac_word[27:14]`. Address 1 writes payload bits [13:0] into `frac_word[13:0]`. In each case the other half of `frac_word` is kept.
- R6: Address 2 sets the divider fields from the payload: `int_div` from payload [13:6], `ref_sel` from [5:4], `cp_cur` from [3:2] and `cp_comp` from [1:0].
- R7: Address 3 sets the configuration flags from the payload: `mod_en` from payload bit 11, `buf_en` from bit 10, `int_mode` from bit 3, `pwr_dn` from bit 2 and `cp_double` from bit 0. Payload bits 13, 12, 9:4 and 1 are ignored.
- R8: While `pwr_dn` is 1, the port still accepts and commits words.
- R9: While `hw_shdn_n` is low, serial traffic is ignored and all registers hold their values.
- R10: A committed value appears on the outputs exactly three system clock edges after the edge at which `ser_en_n` is first sampled high.
- R11: `ser_clk` edges that arrive while `ser_en_n` is high have no effect. No bits carry over from one frame to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_shdn_n | input | 1 | Active-low hardware shutdown that freezes the port |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge commits the word |
| frac_word | output | 28 | Fractional divide value |
| int_div | output | 8 | Integer divide value |
| ref_sel | output | 2 | Reference divider select |
| cp_cur | output | 2 | Charge-pump current select |
| cp_comp | output | 2 | Charge-pump compensation setting |
| mod_en | output | 1 | Software modulator enable |
| buf_en | output | 1 | Software LO buffer enable |
| int_mode | output | 1 | Integer-only mode (disables the fractional modulator) |
| pwr_dn | output | 1 | Software power-down |
| cp_double | output | 1 | Doubles the charge-pump current |

## Verification
Payloads with alternating and sparse bit patterns are written to each address in turn. This separates the two fraction halves from each other and shows any shift in bit order or field position. Frames of 8, 15 and 17 bits, serial clocks given while the enable is high, and a frame sent during hardware shutdown all test that a bad or blocked frame changes nothing. A later good frame then shows that the port has recovered. A reference model compares every output on every clock, which fixes the three-edge commit latency.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 2;
  localparam int PAY_W  = WORD_W - ADDR_W;
  localparam int FRAC_W = 2 * PAY_W;
  localparam int NREG   = 1 << ADDR_W;
  localparam int INT_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_FRAC_HI = 2'd0,
    A_FRAC_LO = 2'd1,
    A_DIV     = 2'd2,
    A_CFG     = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [INT_W-1:0] int_div;
    logic [1:0]       ref_sel;
    logic [1:0]       cp_cur;
    logic [1:0]       cp_comp;
  } div_fields_t;

  typedef struct packed {
    logic mod_en;
    logic buf_en;
    logic int_mode;
    logic pwr_dn;
    logic cp_double;
  } cfg_fields_t;

  function automatic logic [ADDR_W-1:0] addr_of(input logic [WORD_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [PAY_W-1:0] payload_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:ADDR_W];
  endfunction

  function automatic div_fields_t div_from(input logic [PAY_W-1:0] p);
    div_fields_t d;
    d.int_div = p[13:6];
    d.ref_sel = p[5:4];
    d.cp_cur  = p[3:2];
    d.cp_comp = p[1:0];
    return d;
  endfunction

  function automatic cfg_fields_t cfg_from(input logic [PAY_W-1:0] p);
    cfg_fields_t c;
    c.mod_en    = p[11];
    c.buf_en    = p[10];
    c.int_mode  = p[3];
    c.pwr_dn    = p[2];
    c.cp_double = p[0];
    return c;
  endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= INIT;
      prev <= INIT;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;

endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              en_lvl,
  input  logic              sclk_rise,
  input  logic              sdata,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              full
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (!active || en_lvl) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      word <= {word[WORD_W-2:0], sdata};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign full = (bit_cnt == CNT_FULL);

endmodule

// File: rtl/scfg_bank.sv
module scfg_bank
  import scfg_pkg::*;
#(
  parameter int INT_RST = 35
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [WORD_W-1:0]  word,
  output logic [FRAC_W-1:0]  frac,
  output div_fields_t        div,
  output cfg_fields_t        cfg,
  output logic [NREG-1:0]    wen
);

  localparam div_fields_t DIV_RST = '{int_div: INT_W'(INT_RST), ref_sel: 2'd0,
                                      cp_cur: 2'd0, cp_comp: 2'd0};
  localparam cfg_fields_t CFG_RST = '{mod_en: 1'b1, buf_en: 1'b1, int_mode: 1'b0,
                                      pwr_dn: 1'b0, cp_double: 1'b0};

  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  pay;
  logic [PAY_W-1:0]  frac_hi, frac_lo;

  assign addr = addr_of(word);
  assign pay  = payload_of(word);

  for (genvar a = 0; a < NREG; a++) begin : g_wen
    assign wen[a] = commit && (addr == ADDR_W'(a));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              frac_hi <= '0;
    else if (wen[A_FRAC_HI]) frac_hi <= pay;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              frac_lo <= '0;
    else if (wen[A_FRAC_LO]) frac_lo <= pay;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div <= DIV_RST;
    else if (wen[A_DIV]) div <= div_from(pay);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg <= CFG_RST;
    else if (wen[A_CFG]) cfg <= cfg_from(pay);
  end

  assign frac = {frac_hi, frac_lo};

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import scfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INT_RST     = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_shdn_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en_n,
  output logic [FRAC_W-1:0] frac_word,
  output logic [INT_W-1:0]  int_div,
  output logic [1:0]        ref_sel,
  output logic [1:0]        cp_cur,
  output logic [1:0]        cp_comp,
  output logic              mod_en,
  output logic              buf_en,
  output logic              int_mode,
  output logic              pwr_dn,
  output logic              cp_double
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam int P_CLK = 0;
  localparam int P_DAT = 1;
  localparam int P_EN  = 2;

  logic [2:0]        pin_q, pin_rise, pin_fall;
  logic              sclk_rise, en_lvl, en_rise;
  logic [WORD_W-1:0] sh_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              sh_full;
  logic              commit;
  logic [NREG-1:0]   wen;
  div_fields_t       div;
  cfg_fields_t       cfg;

  scfg_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ser_en_n, ser_data, ser_clk}),
    .q    (pin_q),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign sclk_rise = pin_rise[P_CLK];
  assign en_lvl    = pin_q[P_EN];
  assign en_rise   = pin_rise[P_EN];

  scfg_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (hw_shdn_n),
    .en_lvl   (en_lvl),
    .sclk_rise(sclk_rise),
    .sdata    (pin_q[P_DAT]),
    .word     (sh_word),
    .bit_cnt  (bit_cnt),
    .full     (sh_full)
  );

  assign commit = en_rise && sh_full && hw_shdn_n;

  scfg_bank #(.INT_RST(INT_RST)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .commit(commit),
    .word  (sh_word),
    .frac  (frac_word),
    .div   (div),
    .cfg   (cfg),
    .wen   (wen)
  );

  assign int_div   = div.int_div;
  assign ref_sel   = div.ref_sel;
  assign cp_cur    = div.cp_cur;
  assign cp_comp   = div.cp_comp;
  assign mod_en    = cfg.mod_en;
  assign buf_en    = cfg.buf_en;
  assign int_mode  = cfg.int_mode;
  assign pwr_dn    = cfg.pwr_dn;
  assign cp_double = cfg.cp_double;

endmodule

// File: rtl/scfg_checker.sv
module scfg_checker #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_shdn_n,
  input logic [2:0]       pin_q,
  input logic [2:0]       pin_fall,
  input logic             sclk_rise,
  input logic             en_lvl,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [3:0]       wen,
  input logic [27:0]      frac_word,
  input logic [7:0]       int_div,
  input logic [1:0]       ref_sel,
  input logic [1:0]       cp_cur,
  input logic [1:0]       cp_comp,
  input logic             mod_en,
  input logic             buf_en,
  input logic             int_mode,
  input logic             pwr_dn,
  input logic             cp_double
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen));

  assert_commit_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wen) |-> (bit_cnt == FULL));

  assert_frac_hi_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frac_word[27:14]) |-> $past(wen[0]));

  assert_frac_lo_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frac_word[13:0]) |-> $past(wen[1]));

  assert_div_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({int_div, ref_sel, cp_cur, cp_comp}) |-> $past(wen[2]));

  assert_cfg_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mod_en, buf_en, int_mode, pwr_dn, cp_double}) |-> $past(wen[3]));

  assert_hw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!hw_shdn_n) |-> ($stable(frac_word) && $stable(int_div) &&
                           $stable({mod_en, buf_en, int_mode, pwr_dn, cp_double})));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !en_lvl && hw_shdn_n && bit_cnt < FULL) |=>
      (bit_cnt == $past(bit_cnt) + 1'b1));

  assert_count_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lvl || pin_fall[2]) |=> (bit_cnt == '0 || !$past(pin_q[2])));

endmodule

bind serial_cfg_port scfg_checker #(.WORD_W(scfg_pkg::WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hw_shdn_n(hw_shdn_n),
  .pin_q    (pin_q),
  .pin_fall (pin_fall),
  .sclk_rise(sclk_rise),
  .en_lvl   (en_lvl),
  .bit_cnt  (bit_cnt),
  .wen      (wen),
  .frac_word(frac_word),
  .int_div  (int_div),
  .ref_sel  (ref_sel),
  .cp_cur   (cp_cur),
  .cp_comp  (cp_comp),
  .mod_en   (mod_en),
  .buf_en   (buf_en),
  .int_mode (int_mode),
  .pwr_dn   (pwr_dn),
  .cp_double(cp_double)
);

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_shdn_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_en_n = 1'b1;
  logic [27:0] frac_word;
  logic [7:0]  int_div;
  logic [1:0]  ref_sel, cp_cur, cp_comp;
  logic        mod_en, buf_en, int_mode, pwr_dn, cp_double;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int e_frac = 0, e_int = 35, e_ref = 0, e_cur = 0, e_comp = 0;
  int e_mod = 1, e_buf = 1, e_intm = 0, e_pd = 0, e_cpd = 0;
  int pend_cnt = 0;
  int pend_word = 0;

  always #10 clk = ~clk;

  serial_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .hw_shdn_n(hw_shdn_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_en_n(ser_en_n),
    .frac_word(frac_word), .int_div(int_div), .ref_sel(ref_sel),
    .cp_cur(cp_cur), .cp_comp(cp_comp), .mod_en(mod_en), .buf_en(buf_en),
    .int_mode(int_mode), .pwr_dn(pwr_dn), .cp_double(cp_double)
  );

  // Behavioural decode of a committed word (payload above, address in the two low bits).
  task automatic model_apply(input int w);
    int a, p;
    a = w % 4;
    p = w / 4;
    case (a)
      0: e_frac = (e_frac % 16384) + p * 16384;
      1: e_frac = (e_frac / 16384) * 16384 + p;
      2: begin
        e_int = p / 64; e_ref = (p / 16) % 4; e_cur = (p / 4) % 4; e_comp = p % 4;
      end
      default: begin
        e_mod = (p / 2048) % 2; e_buf = (p / 1024) % 2; e_intm = (p / 8) % 2;
        e_pd = (p / 4) % 2; e_cpd = p % 2;
      end
    endcase
  endtask

  // R10: the model takes the word on the third edge after ser_en_n is raised.
  always @(posedge clk) begin
    if (pend_cnt > 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0) model_apply(pend_word);
    end
  end

  function automatic logic [63:0] exp_vec();
    return {4'h0, 28'(e_frac), 8'(e_int), 2'(e_ref), 2'(e_cur), 2'(e_comp),
            1'(e_mod), 1'(e_buf), 1'(e_intm), 1'(e_pd), 1'(e_cpd), 7'h0};
  endfunction

  function automatic logic [63:0] got_vec();
    return {4'h0, frac_word, int_div, ref_sel, cp_cur, cp_comp,
            mod_en, buf_en, int_mode, pwr_dn, cp_double, 7'h0};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (got_vec() !== exp_vec()) begin
        errors++;
        $display("FAIL R10 cycle model: got %h expected %h", got_vec(), exp_vec());
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends n serial bits of w, MSB first (bits past 16 are zero), then raises the enable.
  task automatic send_raw(input logic [15:0] w, input int n);
    ser_en_n = 1'b0;
    wait_n(4);
    for (int i = 0; i < n; i++) begin
      ser_clk  = 1'b0;
      ser_data = (i < 16) ? w[15-i] : 1'b0;
      wait_n(4);
      ser_clk = 1'b1;
      wait_n(4);
    end
    ser_clk = 1'b0;
    wait_n(4);
    ser_en_n = 1'b1;
    if (n == 16 && hw_shdn_n) begin
      pend_word = int'(w);
      pend_cnt  = 3;
    end
    wait_n(6);
  endtask

  function automatic logic [15:0] mk(input logic [13:0] p, input logic [1:0] a);
    return {p, a};
  endfunction

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset values
    chk("R1 frac", 32'(frac_word), 0);
    chk("R1 int_div", 32'(int_div), 35);
    chk("R1 enables", {29'h0, mod_en, buf_en, pwr_dn}, 32'b110);
    chk("R1 others", {22'h0, ref_sel, cp_cur, cp_comp, int_mode, cp_double, 2'b0}, 0);

    // R2/R5 upper fraction half
    send_raw(mk(14'h0399, 2'd0), 16);
    chk("R5 frac hi", 32'(frac_word), 32'h0399 << 14);
    // R5 lower fraction half keeps the upper half
    send_raw(mk(14'h2666, 2'd1), 16);
    chk("R5 frac both", 32'(frac_word), (32'h0399 << 14) | 32'h2666);
    chk("R2 raw word", 32'(mk(14'h2666, 2'd1)), 32'h9999);

    // R6 divider fields: int 86, ref 2, cur 1, comp 3
    send_raw(mk(14'((86 << 6) | (2 << 4) | (1 << 2) | 3), 2'd2), 16);
    chk("R6 int_div", 32'(int_div), 86);
    chk("R6 small fields", {26'h0, ref_sel, cp_cur, cp_comp}, {26'h0, 2'd2, 2'd1, 2'd3});
    chk("R3 frac untouched", 32'(frac_word), (32'h0399 << 14) | 32'h2666);

    // R7 config with ignored bits 9 and 1 set, mod_en cleared
    send_raw(mk(14'h060F, 2'd3), 16);
    chk("R7 flags", {27'h0, mod_en, buf_en, int_mode, pwr_dn, cp_double}, 32'b01111);

    // R8 writes still land while pwr_dn is set
    send_raw(mk(14'h1234, 2'd1), 16);
    chk("R8 write under pwr_dn", 32'(frac_word[13:0]), 32'h1234);

    // R4 short and long frames are dropped
    send_raw(mk(14'(200 << 6), 2'd2), 15);
    chk("R4 15 bits", 32'(int_div), 86);
    send_raw(mk(14'(201 << 6), 2'd2), 17);
    chk("R4 17 bits", 32'(int_div), 86);

    // R9 hardware shutdown freezes the port
    hw_shdn_n = 1'b0;
    wait_n(2);
    send_raw(mk(14'h3FFF, 2'd0), 16);
    chk("R9 frozen", 32'(frac_word[27:14]), 32'h0399);
    hw_shdn_n = 1'b1;
    wait_n(2);
    send_raw(mk(14'h1555, 2'd0), 16);
    chk("R9 resumed", 32'(frac_word[27:14]), 32'h1555);

    // R11 clocks with enable high, then a partial frame, then a good frame
    for (int k = 0; k < 5; k++) begin
      ser_data = 1'b1; ser_clk = 1'b1; wait_n(4);
      ser_clk = 1'b0; wait_n(4);
    end
    chk("R11 idle clocks", 32'(frac_word[13:0]), 32'h1234);
    send_raw(16'hFFFF, 8);
    send_raw(mk(14'h0AAA, 2'd1), 16);
    chk("R11 clean frame", 32'(frac_word[13:0]), 32'h0AAA);

    // R3/R7 restore enables; fractions must stay
    send_raw(mk(14'h0C00, 2'd3), 16);
    chk("R7 restore", {27'h0, mod_en, buf_en, int_mode, pwr_dn, cp_double}, 32'b11000);
    chk("R3 frac kept", 32'(frac_word), (32'h1555 << 14) | 32'h0AAA);

    wait_n(4);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule